// File: doc/BRIEF.md
# Sectored External Memory Bus Controller

This block lets a CPU reach memory and peripherals on a multiplexed 8-bit parallel bus. A data access whose address lies above the last internal SRAM location becomes one external bus cycle, but only while the external-memory enable is set. When the enable is clear, or the address is internal, the request is dropped and the bus stays idle.

Each external cycle runs in a fixed order. First comes an address phase, with the latch-enable high and the low address byte on the shared lines. In the next cycle the latch-enable is low while the low byte is still held. Then a read or write strobe is held low for one cycle plus the wait states. The wait-state count comes from one of two sectors. The sector boundary is set by a programmable value compared against the top address bits. The slowest setting also inserts a cycle of address hold before the bus is free again.

Software sets how many high-address pins are driven; the others are released. An optional keeper makes the shared data lines hold the last value driven onto them whenever the controller is not driving them. The CPU is stalled by a busy output for the whole cycle, and read data is presented on a held output.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, busy and latch-enable are low, both strobes are high, no data or high-address pin is driven, and the read data output is 0.
- R2: A request is ignored, with busy, latch-enable and both strobes staying inactive, when the enable is clear or the address is at or below the internal top (default 0x10FF).
- R3: The cycle after an accepted request shows latch-enable high, the high-address bits driven, and the low address byte driven on the data lines. The next cycle shows latch-enable low with the low byte still driven and both strobes high. The strobe phase follows.
- R4: Wait setting 0, 1, 2 or 3 keeps the active strobe low for 1, 2, 3 or 3 consecutive cycles.
- R5: Busy stays high for 3, 4, 5 or 6 cycles for wait settings 0 to 3. Setting 3 adds one cycle after the strobe rises, in which no strobe is low and the data lines are not driven.
- R6: The upper-sector wait setting applies when the split value is nonzero and the top split bits of the address (bits 15:13 by default) are greater than or equal to it. Otherwise the lower-sector setting applies.
- R7: During an access, high-address pin i is driven (its enable bit is 1) exactly when i is below the programmed count, saturating at 8. Undriven pins output 0, and no pin is driven while idle.
- R8: In a write, the data lines carry the write byte with output enable high in every cycle the write strobe is low, and they are released when the strobe rises.
- R9: In a read, the data lines are not driven while the read strobe is low. The read data output takes the bus value present in the last strobe cycle and keeps it until the next read.
- R10: With the keeper enabled, the data output holds the last driven value whenever its enable is low, and the keeper-active output is high. With the keeper disabled, the undriven data output is 0.
- R11: A request made while busy is ignored. A request made in the first cycle busy is low is accepted, and busy is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | External-memory enable |
| cfg_keep | input | 1 | Data-line keeper enable |
| cfg_split | input | 3 | Sector boundary on the top address bits; 0 means one sector |
| cfg_wait_lo | input | 2 | Wait setting for the lower sector |
| cfg_wait_hi | input | 2 | Wait setting for the upper sector |
| cfg_hi_bits | input | 4 | Number of high-address pins driven (saturates at 8) |
| cpu_req | input | 1 | Data access request |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write byte |
| cpu_busy | output | 1 | Stall while an external cycle runs |
| cpu_rdata | output | 8 | Last external read byte |
| ext_ahi | output | 8 | High address byte pins |
| ext_ahi_oe | output | 8 | Per-pin drive enable of the high address byte |
| ext_ad_out | output | 8 | Multiplexed address/data output value |
| ext_ad_oe | output | 1 | Drive enable of the multiplexed lines |
| ext_ad_in | input | 8 | Value sampled from the multiplexed lines |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_keep_act | output | 1 | Keeper currently holding the lines |

## Verification
A corrupted phase register shows up within one cycle as a latch-enable pulse that is too long or missing, or as a strobe that rises early or late. A wrong wait count or hold flag changes the busy length and the strobe width, so these are counted per access. A wrong sector or mask decode shows up on the strobe width and on the high-address drive enables from the first cycle of the access. Keeper state errors appear on the data output in the first undriven cycle after a write.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        XB_IDLE  = 3'd0,
        XB_ADDR  = 3'd1,
        XB_LATCH = 3'd2,
        XB_STRB  = 3'd3,
        XB_HOLD  = 3'd4
    } xb_state_e;

    // Extra strobe cycles for each wait setting.
    function automatic logic [1:0] xb_extra_cycles(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // Only the slowest setting adds an address-hold cycle.
    function automatic logic xb_needs_hold(input logic [1:0] sel);
        return sel == 2'd3;
    endfunction

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
    parameter int ADDR_W  = 16,
    parameter int SPLIT_W = 3,
    parameter logic [ADDR_W-1:0] INT_TOP = 16'h10FF
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               ext_en,
    input  logic [SPLIT_W-1:0] split,
    input  logic [1:0]         wait_lo,
    input  logic [1:0]         wait_hi,
    output logic               hit,
    output logic [1:0]         wait_sel
);
    logic [SPLIT_W-1:0] top_bits;
    logic               upper;

    always_comb begin
        top_bits = addr[ADDR_W-1 -: SPLIT_W];
        hit      = ext_en && (addr > INT_TOP);
        upper    = (split != '0) && (top_bits >= split);
        wait_sel = upper ? wait_hi : wait_lo;
    end
endmodule

// File: rtl/xbus_hi_mask.sv
module xbus_hi_mask #(
    parameter int HI_W = 8,
    localparam int HB_W = $clog2(HI_W + 1)
) (
    input  logic [HB_W-1:0] count,
    output logic [HI_W-1:0] mask
);
    for (genvar i = 0; i < HI_W; i++) begin : g_pin
        assign mask[i] = (count > HB_W'(i));
    end
endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drv_en,
    input  logic [DW-1:0] drv_val,
    input  logic          keep_en,
    output logic [DW-1:0] pad_out,
    output logic          keep_act
);
    logic [DW-1:0] last_d, last_q;

    always_comb begin
        last_d   = drv_en ? drv_val : last_q;
        keep_act = keep_en && !drv_en;
        if (drv_en)       pad_out = drv_val;
        else if (keep_en) pad_out = last_q;
        else              pad_out = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= last_d;
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SPLIT_W = 3,
    parameter logic [ADDR_W-1:0] INT_TOP = 16'h10FF,
    localparam int DW   = 8,
    localparam int HI_W = ADDR_W - DW,
    localparam int HB_W = $clog2(HI_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_keep,
    input  logic [SPLIT_W-1:0] cfg_split,
    input  logic [1:0]         cfg_wait_lo,
    input  logic [1:0]         cfg_wait_hi,
    input  logic [HB_W-1:0]    cfg_hi_bits,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DW-1:0]      cpu_wdata,
    output logic               cpu_busy,
    output logic [DW-1:0]      cpu_rdata,
    output logic [HI_W-1:0]    ext_ahi,
    output logic [HI_W-1:0]    ext_ahi_oe,
    output logic [DW-1:0]      ext_ad_out,
    output logic               ext_ad_oe,
    input  logic [DW-1:0]      ext_ad_in,
    output logic               ext_ale,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic               ext_keep_act
);
    typedef struct packed {
        xb_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DW-1:0]     wdata;
        logic [1:0]        cnt;
        logic              hold;
        logic [DW-1:0]     rdata;
    } regs_t;

    regs_t d, q;

    logic            hit;
    logic [1:0]      wait_sel;
    logic [HI_W-1:0] hi_mask;
    logic            strobe;
    logic            drv_en;
    logic [DW-1:0]   drv_val;

    xbus_decode #(
        .ADDR_W (ADDR_W),
        .SPLIT_W(SPLIT_W),
        .INT_TOP(INT_TOP)
    ) u_decode (
        .addr    (cpu_addr),
        .ext_en  (cfg_en),
        .split   (cfg_split),
        .wait_lo (cfg_wait_lo),
        .wait_hi (cfg_wait_hi),
        .hit     (hit),
        .wait_sel(wait_sel)
    );

    xbus_hi_mask #(.HI_W(HI_W)) u_mask (
        .count(cfg_hi_bits),
        .mask (hi_mask)
    );

    always_comb begin
        d = q;
        case (q.st)
            XB_IDLE: begin
                if (cpu_req && hit) begin
                    d.st    = XB_ADDR;
                    d.addr  = cpu_addr;
                    d.we    = cpu_we;
                    d.wdata = cpu_wdata;
                    d.cnt   = xb_extra_cycles(wait_sel);
                    d.hold  = xb_needs_hold(wait_sel);
                end
            end
            XB_ADDR:  d.st = XB_LATCH;
            XB_LATCH: d.st = XB_STRB;
            XB_STRB: begin
                if (q.cnt == 2'd0) begin
                    if (!q.we) d.rdata = ext_ad_in;
                    d.st = q.hold ? XB_HOLD : XB_IDLE;
                end else begin
                    d.cnt = q.cnt - 2'd1;
                end
            end
            XB_HOLD:  d.st = XB_IDLE;
            default:  d.st = XB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: XB_IDLE, addr: '0, we: 1'b0, wdata: '0,
                   cnt: 2'd0, hold: 1'b0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        strobe     = (q.st == XB_STRB);
        cpu_busy   = (q.st != XB_IDLE);
        cpu_rdata  = q.rdata;
        ext_ale    = (q.st == XB_ADDR);
        ext_rd_n   = !(strobe && !q.we);
        ext_wr_n   = !(strobe && q.we);
        drv_en     = (q.st == XB_ADDR) || (q.st == XB_LATCH) || (strobe && q.we);
        drv_val    = strobe ? q.wdata : q.addr[DW-1:0];
        ext_ahi_oe = cpu_busy ? hi_mask : '0;
        ext_ahi    = q.addr[ADDR_W-1:DW] & ext_ahi_oe;
        ext_ad_oe  = drv_en;
    end

    xbus_keeper #(.DW(DW)) u_keep (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_en  (drv_en),
        .drv_val (drv_val),
        .keep_en (cfg_keep),
        .pad_out (ext_ad_out),
        .keep_act(ext_keep_act)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int HI_W = 8,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_busy,
    input logic [DW-1:0]   cpu_rdata,
    input logic [HI_W-1:0] ext_ahi,
    input logic [HI_W-1:0] ext_ahi_oe,
    input logic [DW-1:0]   ext_ad_out,
    input logic            ext_ad_oe,
    input logic            ext_ale,
    input logic            ext_rd_n,
    input logic            ext_wr_n,
    input logic            ext_keep_act
);
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!cpu_busy && !ext_ale && ext_rd_n && ext_wr_n
                                      && !ext_ad_oe && ext_ahi_oe == '0 && cpu_rdata == '0);
        end
    end

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_busy |-> (ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe && ext_ahi_oe == '0));

    a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |=> (!ext_ale && cpu_busy && ext_rd_n && ext_wr_n && ext_ad_oe));

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    a_r7_hi_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ahi & ~ext_ahi_oe) == '0);

    a_r8_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n |-> ext_ad_oe);

    a_r9_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> !ext_ad_oe);

    a_r10_keeper_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_ad_oe && ext_keep_act && $past(!ext_ad_oe && ext_keep_act)) |-> $stable(ext_ad_out));

    a_r11_start_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_busy) |-> ext_ale);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.HI_W(HI_W), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_busy    (cpu_busy),
    .cpu_rdata   (cpu_rdata),
    .ext_ahi     (ext_ahi),
    .ext_ahi_oe  (ext_ahi_oe),
    .ext_ad_out  (ext_ad_out),
    .ext_ad_oe   (ext_ad_oe),
    .ext_ale     (ext_ale),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n),
    .ext_keep_act(ext_keep_act)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_keep = 1'b0;
    logic [2:0]  cfg_split = '0;
    logic [1:0]  cfg_wait_lo = '0, cfg_wait_hi = '0;
    logic [3:0]  cfg_hi_bits = 4'd8;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_busy;
    logic [7:0]  cpu_rdata;
    logic [7:0]  ext_ahi, ext_ahi_oe, ext_ad_out;
    logic        ext_ad_oe;
    logic [7:0]  ext_ad_in = '0;
    logic        ext_ale, ext_rd_n, ext_wr_n, ext_keep_act;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] last_rd = '0;

    always #2 clk = ~clk;

    xbus_ctrl uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wait_of(input logic [1:0] s);
        return (s == 2'd0) ? 0 : (s == 2'd1) ? 1 : 2;
    endfunction

    function automatic logic [1:0] sel_of(input logic [15:0] a);
        if (cfg_split != 3'd0 && a[15:13] >= cfg_split) return cfg_wait_hi;
        return cfg_wait_lo;
    endfunction

    function automatic logic [7:0] mask_of(input logic [3:0] n);
        int k;
        k = (n > 4'd8) ? 8 : int'(n);
        return 8'((1 << k) - 1);
    endfunction

    // One request; returns at a negedge with the bus idle.
    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] wd,
                          input logic [7:0] rv, input bit poke_busy);
        bit         ext;
        int         w, busy_n, strb_n, exp_busy;
        logic [1:0] s;
        logic [7:0] m;
        ext = cfg_en && (a > 16'h10FF);
        s = sel_of(a);
        w = wait_of(s);
        m = mask_of(cfg_hi_bits);
        exp_busy = 3 + w + ((s == 2'd3) ? 1 : 0);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; ext_ad_in = rv;
        @(negedge clk);
        cpu_req = 1'b0;
        if (!ext) begin
            for (int i = 0; i < 3; i++) begin
                chk(!cpu_busy && !ext_ale && ext_rd_n && ext_wr_n, "R2 ignored",
                    {cpu_busy, ext_ale, ext_rd_n, ext_wr_n}, 4'b0011);
                @(negedge clk);
            end
            return;
        end
        busy_n = 0; strb_n = 0;
        while (cpu_busy && busy_n < 20) begin
            chk(ext_ahi_oe == m && ext_ahi == (a[15:8] & m), "R7 high pins",
                {ext_ahi_oe, ext_ahi}, {m, a[15:8] & m});
            if (busy_n == 0)
                chk(ext_ale && ext_ad_oe && ext_ad_out == a[7:0], "R3 address phase",
                    {ext_ale, ext_ad_oe, ext_ad_out}, {2'b11, a[7:0]});
            if (busy_n == 1)
                chk(!ext_ale && ext_ad_oe && ext_ad_out == a[7:0] && ext_rd_n && ext_wr_n,
                    "R3 latch phase", {ext_ale, ext_ad_oe, ext_ad_out}, {2'b01, a[7:0]});
            if (busy_n >= 2) begin
                if (!(we ? ext_wr_n : ext_rd_n)) begin
                    strb_n++;
                    if (we)
                        chk(ext_ad_oe && ext_ad_out == wd, "R8 write data",
                            {ext_ad_oe, ext_ad_out}, {1'b1, wd});
                    else
                        chk(!ext_ad_oe, "R9 read release", ext_ad_oe, 0);
                end else begin
                    chk(!ext_ad_oe, "R5 hold cycle undriven", ext_ad_oe, 0);
                end
            end
            if (poke_busy && busy_n == 2) begin
                cpu_req = 1'b1; cpu_we = ~we; cpu_addr = 16'hFFFF;
            end else begin
                cpu_req = 1'b0;
            end
            busy_n++;
            @(negedge clk);
        end
        cpu_req = 1'b0;
        chk(strb_n == 1 + w, "R4 strobe width", strb_n, 1 + w);
        chk(busy_n == exp_busy, "R5 busy length", busy_n, exp_busy);
        chk(s == sel_of(a), "R6 sector", s, s);
        if (!we) last_rd = rv;
        chk(cpu_rdata == last_rd, "R9 read data", cpu_rdata, last_rd);
        if (cfg_keep)
            chk(ext_keep_act && ext_ad_out == (we ? wd : a[7:0]), "R10 keeper holds",
                ext_ad_out, we ? wd : a[7:0]);
        else
            chk(!ext_keep_act && ext_ad_out == 8'h00, "R10 keeper off", ext_ad_out, 0);
        if (poke_busy)
            chk(!cpu_busy, "R11 request while busy ignored", cpu_busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!cpu_busy && !ext_ale && ext_rd_n && ext_wr_n && !ext_ad_oe &&
            ext_ahi_oe == 8'h00 && cpu_rdata == 8'h00, "R1 reset state",
            {cpu_busy, ext_ale, ext_rd_n, ext_wr_n, ext_ad_oe}, 5'b00110);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled, and internal address with enable set
        access(1'b1, 16'h8000, 8'h5A, 8'h00, 1'b0);
        cfg_en = 1'b1;
        access(1'b0, 16'h10FF, 8'h00, 8'h33, 1'b0);

        // R4/R5 all four settings, single sector
        for (int k = 0; k < 4; k++) begin
            cfg_wait_lo = 2'(k);
            access(1'b1, 16'h1100, 8'hA0 + 8'(k), 8'h00, 1'b0);
            access(1'b0, 16'h2345, 8'h00, 8'hC0 + 8'(k), 1'b0);
        end

        // R6 sector split: lower uses 0, upper uses 3
        cfg_split = 3'd4; cfg_wait_lo = 2'd0; cfg_wait_hi = 2'd3;
        access(1'b0, 16'h7FFF, 8'h00, 8'h11, 1'b0);
        access(1'b0, 16'h8000, 8'h00, 8'h22, 1'b0);

        // R7 high pin count corners
        cfg_hi_bits = 4'd0;  access(1'b1, 16'hBEEF, 8'h44, 8'h00, 1'b0);
        cfg_hi_bits = 4'd3;  access(1'b1, 16'hBEEF, 8'h45, 8'h00, 1'b0);
        cfg_hi_bits = 4'd15; access(1'b0, 16'hFEED, 8'h00, 8'h46, 1'b0);

        // R10 keeper on, R11 busy poke, then back-to-back acceptance
        cfg_keep = 1'b1;
        access(1'b1, 16'hC123, 8'h9E, 8'h00, 1'b1);
        cfg_keep = 1'b0;
        access(1'b1, 16'h4444, 8'h71, 8'h00, 1'b0);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h3000;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cpu_busy && ext_ale, "R11 accept when idle", {cpu_busy, ext_ale}, 2'b11);
        while (cpu_busy) @(negedge clk);
        last_rd = ext_ad_in;

        // Random mix
        for (int n = 0; n < 60; n++) begin
            logic [15:0] a;
            cfg_en      = ($urandom % 8) != 0;
            cfg_keep    = 1'($urandom);
            cfg_split   = 3'($urandom);
            cfg_wait_lo = 2'($urandom);
            cfg_wait_hi = 2'($urandom);
            cfg_hi_bits = 4'($urandom % 10);
            a = 16'($urandom);
            if (($urandom % 4) == 0) a = 16'($urandom % 16'h1100);
            access(1'($urandom), a, 8'($urandom), 8'($urandom), (n % 7) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule